// File: doc/BRIEF.md
# Instruction Fetch Cache with Invalidate Control

This block sits between a processor's instruction fetch port and an external memory bus. It is read-only. Lines are only ever loaded from memory, so no line is ever dirty and nothing is written back. While the cache is switched on, a fetch that hits returns its word one cycle after it is accepted. A miss loads the whole line with one incrementing burst. The fetch port gets its word on the beat that carries it, and the rest of the line keeps loading in the background. While the cache is switched off, it neither looks up nor fills, and every fetch becomes one single-word memory read. The lines it already holds are kept.

Software keeps the cache coherent through a small command port, because external writes are never observed. One command drops every line at once. The other drops only the line that holds a given address. A per-way lock mask shields ways from replacement, but the whole-cache command clears locked lines as well. A command that arrives while a line is loading waits until the load ends, and it takes effect before the next fetch is looked up. Reset empties the cache.

The default organisation has 4 ways, 64 sets and 8 words of 32 bits per line. Replacement in each set is round-robin, and locked ways are skipped.

Top module: `ifetch_cache`

## Requirements
- R1: With `cache_on` high, a fetch whose line is resident raises `fetch_rvalid` exactly one cycle after acceptance (`fetch_req && fetch_gnt`) with the stored word, and it makes no memory request. Every accepted fetch gets exactly one response.
- R2: With `cache_on` high, a miss issues one request with `mem_burst`=1 and `mem_addr` equal to the line base (byte address with bits [4:0] zero). Eight beats then fill the line in increasing word order. `fetch_rvalid` rises on the beat whose index equals fetch address bits [4:2]. The request holds its address until `mem_gnt`.
- R3: With `cache_on` low, each fetch makes exactly one request with `mem_burst`=0 at the fetch address and returns that beat. Nothing is filled, and resident lines are still present after the cache is switched back on.
- R4: A command with `maint_op`=0 and `maint_data`=0 invalidates every line, including lines in locked ways. With `maint_op`=0 and nonzero `maint_data`, the command has no effect.
- R5: A command with `maint_op`=1 invalidates only the line holding byte address `maint_data` (set = bits [10:5], tag = bits [31:11]). If that address is not resident, no line changes.
- R6: After reset, no line is valid, `fetch_gnt` and `maint_ready` are high, and `mem_req` and `fetch_rvalid` are low.
- R7: A miss in a set replaces the way named by that set's round-robin pointer, which starts at way 0, or the next unlocked way after it (`lock_mask` bit n locks way n). The pointer then moves to the way after the one filled. Lines in locked ways survive later misses.
- R8: A miss while every way is locked is served as a single-word access (`mem_burst`=0) and is not cached.
- R9: A change to external memory is not seen by a resident line until that line is invalidated.
- R10: A command accepted while a line fill is in progress is held with `maint_ready` low. It is applied after the fill and before the next fetch is accepted: `fetch_gnt` stays low while a command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_on | input | 1 | High enables lookups and fills |
| lock_mask | input | 4 | Per-way replacement lock |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Word-aligned fetch byte address |
| fetch_gnt | output | 1 | Fetch request accepted this cycle |
| fetch_rvalid | output | 1 | Fetch data valid |
| fetch_rdata | output | 32 | Fetch data |
| maint_valid | input | 1 | Maintenance command valid |
| maint_op | input | 1 | 0 = whole cache, 1 = one line |
| maint_data | input | 32 | Address for line command; must be zero for whole-cache command |
| maint_ready | output | 1 | Command accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_addr | output | 32 | Memory byte address |
| mem_burst | output | 1 | 1 = 8-beat line burst, 0 = single word |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The bench first fills a line, then changes the backing memory under it and checks that stale data is returned until a line invalidate. A design that snooped writes, or one that invalidated the wrong line, would return fresh data or miss on a neighbour. Misses land at several word offsets while beats arrive with a gap. This catches a cache that answers only after the whole burst, or that returns the wrong beat. One way is locked while misses cycle through its set, and a whole-cache invalidate is then issued on top of the lock. A policy that evicted locked lines, or an invalidate that skipped them, would change the burst count. A line invalidate is issued mid-fill, which exposes a design that applies it early (the refill would then stay valid) or drops it. The off mode and the all-ways-locked mode are checked by counting single accesses, and a nonzero whole-cache command is checked for having no effect.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
// Shared types for the instruction fetch cache.
// Assumes nothing beyond a synchronous design flow.
package ifc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // ready for a fetch or a pending command
        ST_LOOK,   // tag compare on the captured address
        ST_FREQ,   // line burst requested, awaiting grant
        ST_FILL,   // line beats arriving
        ST_SREQ,   // single access requested, awaiting grant
        ST_SWAIT   // single beat awaited
    } ifc_state_t;

    typedef enum logic {
        MOP_ALL  = 1'b0,
        MOP_LINE = 1'b1
    } ifc_mop_t;
endpackage

// File: rtl/ifc_tag_store.sv
`timescale 1ns/1ps
// Valid bits and tags for every way of every set.
// Compares one set/tag pair against all ways combinationally.
// Assumes fill and clear never target the same line in one cycle.
module ifc_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 64,
    parameter int TAG_W = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  cmp_set,
    input  logic [TAG_W-1:0]         cmp_tag,
    output logic [WAYS-1:0]          hit_vec,
    input  logic                     fill_en,
    input  logic [$clog2(SETS)-1:0]  fill_set,
    input  logic [WAYS-1:0]          fill_way_oh,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic                     clr_all,
    input  logic                     clr_en,
    input  logic [$clog2(SETS)-1:0]  clr_set,
    input  logic [WAYS-1:0]          clr_ways
);
    logic [WAYS-1:0]  vld [SETS];
    logic [TAG_W-1:0] tag [SETS][WAYS];

    // Valid state: reset and whole-cache clear empty it, fills set bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else begin
            if (clr_en)  vld[clr_set]  <= vld[clr_set] & ~clr_ways;
            if (fill_en) vld[fill_set] <= vld[fill_set] | fill_way_oh;
        end
    end

    // Tag write on fill completion.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int w = 0; w < WAYS; w++)
                if (fill_way_oh[w]) tag[fill_set][w] <= fill_tag;
        end
    end

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[cmp_set][w] && (tag[cmp_set][w] == cmp_tag);
    end
endmodule

// File: rtl/ifc_data_store.sv
`timescale 1ns/1ps
// Line data, addressed by set, way and word. One write and one
// asynchronous read port. Assumes SETS, WAYS, WORDS are powers of two.
module ifc_data_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 64,
    parameter int WORDS = 8,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_set,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [$clog2(WORDS)-1:0]  wr_word,
    input  logic [DW-1:0]             wr_data,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    input  logic [$clog2(WAYS)-1:0]   rd_way,
    input  logic [$clog2(WORDS)-1:0]  rd_word,
    output logic [DW-1:0]             rd_data
);
    localparam int IDX_W = $clog2(SETS) + $clog2(WAYS) + $clog2(WORDS);

    logic [DW-1:0] mem [2**IDX_W];

    // Beat write during a line fill.
    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_set, wr_way, wr_word}] <= wr_data;
    end

    assign rd_data = mem[{rd_set, rd_way, rd_word}];
endmodule

// File: rtl/ifc_victim.sv
`timescale 1ns/1ps
// Per-set round-robin victim choice that skips locked ways.
// Reports none_free when every way is locked. Assumes WAYS is a power of two.
module ifc_victim #(
    parameter int WAYS = 4,
    parameter int SETS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set_idx,
    input  logic [WAYS-1:0]          lock_mask,
    output logic [$clog2(WAYS)-1:0]  victim_way,
    output logic                     none_free,
    input  logic                     adv_en,
    input  logic [$clog2(WAYS)-1:0]  adv_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] rr [SETS];

    // Pointer moves past the way just filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr[s] <= '0;
        end else if (adv_en) begin
            rr[set_idx] <= adv_way + WAY_W'(1);
        end
    end

    // First unlocked way at or after the pointer (scan high to low so the lowest offset wins).
    always_comb begin
        logic [WAY_W-1:0] cand;
        none_free  = 1'b1;
        victim_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            cand = rr[set_idx] + WAY_W'(i);
            if (!lock_mask[cand]) begin
                victim_way = cand;
                none_free  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ifetch_cache.sv
`timescale 1ns/1ps
// Read-only instruction cache with enable, lock mask and invalidate commands.
// One fetch outstanding at a time; a command waits for the idle state and
// takes precedence over the next fetch. Assumes word-aligned fetch addresses
// and power-of-two geometry.
module ifetch_cache
    import ifc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 64,
    parameter int LINE_WORDS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cache_on,
    input  logic [WAYS-1:0] lock_mask,
    input  logic            fetch_req,
    input  logic [AW-1:0]   fetch_addr,
    output logic            fetch_gnt,
    output logic            fetch_rvalid,
    output logic [DW-1:0]   fetch_rdata,
    input  logic            maint_valid,
    input  logic            maint_op,
    input  logic [AW-1:0]   maint_data,
    output logic            maint_ready,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_burst,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int BYTE_W = $clog2(DW / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LB     = BYTE_W + OFF_W;
    localparam int TAG_W  = AW - SET_W - LB;

    ifc_state_t       state;
    logic [AW-1:0]    req_addr;
    logic [OFF_W-1:0] beat_cnt;
    logic [WAY_W-1:0] fill_way;
    logic             pend_v;
    ifc_mop_t         pend_op;
    logic [AW-1:0]    pend_data;

    logic [SET_W-1:0] req_set, cmp_set;
    logic [TAG_W-1:0] req_tag, cmp_tag;
    logic [OFF_W-1:0] req_word;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_idx, victim_way;
    logic             none_free, look_hit, apply_maint;
    logic             data_we, fill_done, clr_all, clr_en;
    logic [DW-1:0]    rd_data;

    assign req_set  = req_addr[LB +: SET_W];
    assign req_tag  = req_addr[AW-1 -: TAG_W];
    assign req_word = req_addr[BYTE_W +: OFF_W];

    assign apply_maint = (state == ST_IDLE) && pend_v;
    assign cmp_set     = apply_maint ? pend_data[LB +: SET_W]   : req_set;
    assign cmp_tag     = apply_maint ? pend_data[AW-1 -: TAG_W] : req_tag;
    assign look_hit    = cache_on && (|hit_vec);
    assign clr_all     = apply_maint && (pend_op == MOP_ALL) && (pend_data == '0);
    assign clr_en      = apply_maint && (pend_op == MOP_LINE);
    assign data_we     = (state == ST_FILL) && mem_rvalid;
    assign fill_done   = data_we && (beat_cnt == OFF_W'(LINE_WORDS - 1));

    // Encode the hitting way for the data read.
    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_idx = WAY_W'(w);
    end

    ifc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .cmp_set(cmp_set), .cmp_tag(cmp_tag), .hit_vec(hit_vec),
        .fill_en(fill_done), .fill_set(req_set),
        .fill_way_oh(WAYS'(1) << fill_way), .fill_tag(req_tag),
        .clr_all(clr_all), .clr_en(clr_en), .clr_set(cmp_set), .clr_ways(hit_vec)
    );

    ifc_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(LINE_WORDS), .DW(DW)) data_i (
        .clk(clk), .wr_en(data_we), .wr_set(req_set), .wr_way(fill_way),
        .wr_word(beat_cnt), .wr_data(mem_rdata),
        .rd_set(req_set), .rd_way(hit_idx), .rd_word(req_word), .rd_data(rd_data)
    );

    ifc_victim #(.WAYS(WAYS), .SETS(SETS)) victim_i (
        .clk(clk), .rst_n(rst_n), .set_idx(req_set), .lock_mask(lock_mask),
        .victim_way(victim_way), .none_free(none_free),
        .adv_en(fill_done), .adv_way(fill_way)
    );

    // Edge handshakes and bus request.
    assign fetch_gnt   = (state == ST_IDLE) && !pend_v;
    assign maint_ready = !pend_v;
    assign mem_req     = (state == ST_FREQ) || (state == ST_SREQ);
    assign mem_burst   = (state == ST_FREQ);
    assign mem_addr    = (state == ST_FREQ) ? {req_addr[AW-1:LB], {LB{1'b0}}} : req_addr;

    // Fetch response: hit data, critical beat of a fill, or single beat.
    always_comb begin
        fetch_rvalid = 1'b0;
        fetch_rdata  = '0;
        case (state)
            ST_LOOK:  begin fetch_rvalid = look_hit; fetch_rdata = rd_data; end
            ST_FILL:  begin fetch_rvalid = mem_rvalid && (beat_cnt == req_word); fetch_rdata = mem_rdata; end
            ST_SWAIT: begin fetch_rvalid = mem_rvalid; fetch_rdata = mem_rdata; end
            default:  ;
        endcase
    end

    // Command holding register: capture when free, release when applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_op   <= MOP_ALL;
            pend_data <= '0;
        end else if (maint_valid && maint_ready) begin
            pend_v    <= 1'b1;
            pend_op   <= ifc_mop_t'(maint_op);
            pend_data <= maint_data;
        end else if (apply_maint) begin
            pend_v    <= 1'b0;
        end
    end

    // Fetch sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            req_addr <= '0;
            beat_cnt <= '0;
            fill_way <= '0;
        end else begin
            case (state)
                ST_IDLE: if (fetch_gnt && fetch_req) begin
                    req_addr <= fetch_addr;
                    state    <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (look_hit) state <= ST_IDLE;
                    else if (cache_on && !none_free) begin
                        fill_way <= victim_way;
                        state    <= ST_FREQ;
                    end else state <= ST_SREQ;
                end
                ST_FREQ: if (mem_gnt) begin
                    beat_cnt <= '0;
                    state    <= ST_FILL;
                end
                ST_FILL: if (mem_rvalid) begin
                    beat_cnt <= beat_cnt + OFF_W'(1);
                    if (fill_done) state <= ST_IDLE;
                end
                ST_SREQ:  if (mem_gnt) state <= ST_SWAIT;
                ST_SWAIT: if (mem_rvalid) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ifetch_cache_chk.sv
`timescale 1ns/1ps
// Protocol checker for ifetch_cache, attached by bind.
module ifetch_cache_chk #(
    parameter int AW = 32,
    parameter int LB = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic          fetch_gnt,
    input logic          fetch_rvalid,
    input logic          maint_ready,
    input logic          mem_req,
    input logic          mem_burst,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr
);
    logic busy;

    // Tracks whether an accepted fetch still awaits its response.
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy <= 1'b0;
        else if (fetch_req && fetch_gnt) busy <= 1'b1;
        else if (fetch_rvalid)           busy <= 1'b0;
    end

    // R1
    resp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rvalid |-> busy);

    // R1
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_gnt) |-> !busy);

    // R2
    line_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_burst) |-> (mem_addr[LB-1:0] == '0));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_burst)));

    // R10
    cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_gnt |-> maint_ready);
endmodule

bind ifetch_cache ifetch_cache_chk #(.AW(AW), .LB(LB)) chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_gnt(fetch_gnt),
    .fetch_rvalid(fetch_rvalid), .maint_ready(maint_ready), .mem_req(mem_req),
    .mem_burst(mem_burst), .mem_gnt(mem_gnt), .mem_addr(mem_addr)
);

// File: tb/ifetch_cache_tb_top.sv
`timescale 1ns/1ps
module ifetch_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_on = 1'b1;
    logic [3:0]  lock_mask = 4'h0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_gnt, fetch_rvalid, maint_ready, mem_req, mem_burst;
    logic [31:0] fetch_rdata, mem_addr;
    logic        maint_valid = 1'b0;
    logic        maint_op = 1'b0;
    logic [31:0] maint_data = '0;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    ifetch_cache dut_i (.*);

    int total = 0, bad = 0, n_burst = 0, n_single = 0, beat_idx = -1, n_resp = 0;
    bit done = 0;

    // Behavioural memory and reference cache state.
    logic [31:0] ovr [logic [31:0]];
    bit          mv  [64][4];
    logic [20:0] mt  [64][4];
    logic [31:0] md  [64][4][8];
    int          mrr [64];

    function automatic logic [31:0] memv(input logic [31:0] a);
        if (ovr.exists(a)) return ovr[a];
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tg, act, exp);
        end
    endtask

    // Memory responder: grant, then beats (gap before beat 3).
    initial begin
        logic [31:0] a;
        int n;
        forever begin
            @(posedge clk); #1;
            if (mem_req) begin
                mem_gnt = 1'b1; a = mem_addr; n = mem_burst ? 8 : 1;
                if (mem_burst) n_burst++; else n_single++;
                @(posedge clk); #1; mem_gnt = 1'b0;
                for (int k = 0; k < n; k++) begin
                    if (k == 3) begin mem_rvalid = 1'b0; @(posedge clk); #1; end
                    mem_rvalid = 1'b1; mem_rdata = memv(a + 32'(4 * k)); beat_idx = k;
                    @(posedge clk); #1;
                end
                mem_rvalid = 1'b0; beat_idx = -1;
            end
        end
    end

    // Per-clock response counter.
    initial forever begin
        @(posedge clk); #2;
        if (rst_n && fetch_rvalid) n_resp++;
    end

    function automatic int find_way(input logic [31:0] a);
        for (int w = 0; w < 4; w++)
            if (mv[a[10:5]][w] && mt[a[10:5]][w] == a[31:11]) return w;
        return -1;
    endfunction

    task automatic fetch(input logic [31:0] a, input string tg);
        int kind, way, lat, b0, s0, r0, rb, st, c;
        logic [31:0] exp, got;
        st = int'(a[10:5]);
        way = find_way(a);
        if (!cache_on) begin kind = 2; exp = memv(a); end
        else if (way >= 0) begin kind = 0; exp = md[st][way][a[4:2]]; end
        else begin
            kind = 2; exp = memv(a);
            for (int i = 3; i >= 0; i--) begin
                c = (mrr[st] + i) % 4;
                if (!lock_mask[c]) begin kind = 1; way = c; end
            end
            if (kind == 1) begin
                for (int k = 0; k < 8; k++) md[st][way][k] = memv({a[31:5], 5'b0} + 32'(4 * k));
                mv[st][way] = 1; mt[st][way] = a[31:11]; mrr[st] = (way + 1) % 4;
                exp = md[st][way][a[4:2]];
            end
        end
        b0 = n_burst; s0 = n_single; r0 = n_resp;
        @(negedge clk);
        while (!fetch_gnt) @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk); fetch_req = 1'b0; lat = 1;
        while (!fetch_rvalid && lat < 300) begin @(negedge clk); lat++; end
        got = fetch_rdata; rb = beat_idx;
        chk(got == exp, tg, got, exp);
        if (kind == 0) begin
            chk(lat == 1, "R1 hit latency", 32'(lat), 32'd1);
            chk(n_burst == b0 && n_single == s0, "R1 hit no access", 32'(n_burst + n_single), 32'(b0 + s0));
        end else if (kind == 1) begin
            chk(n_burst == b0 + 1 && n_single == s0, "R2 one burst", 32'(n_burst), 32'(b0 + 1));
            chk(rb == int'(a[4:2]), "R2 critical beat", 32'(rb), 32'(a[4:2]));
        end else begin
            chk(n_single == s0 + 1 && n_burst == b0, cache_on ? "R8 single when locked" : "R3 single when off",
                32'(n_single), 32'(s0 + 1));
        end
        @(negedge clk);
        chk(n_resp == r0 + 1, "R1 one response", 32'(n_resp), 32'(r0 + 1));
    endtask

    task automatic model_maint(input logic op, input logic [31:0] d);
        int w;
        if (!op) begin
            if (d == 0) foreach (mv[s, x]) mv[s][x] = 0;
        end else begin
            w = find_way(d);
            if (w >= 0) mv[d[10:5]][w] = 0;
        end
    endtask

    task automatic maint(input logic op, input logic [31:0] d);
        @(negedge clk);
        while (!maint_ready) @(negedge clk);
        maint_valid = 1'b1; maint_op = op; maint_data = d;
        @(negedge clk); maint_valid = 1'b0;
        model_maint(op, d);
    endtask

    function automatic logic [31:0] s3(input int k);
        return 32'(k) * 32'h800 + 32'h60;
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w0;
        foreach (mv[s, x]) mv[s][x] = 0;
        foreach (mrr[s]) mrr[s] = 0;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(fetch_gnt && maint_ready && !mem_req && !fetch_rvalid, "R6 in reset",
            {28'd0, fetch_gnt, maint_ready, mem_req, fetch_rvalid}, 32'hC);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_gnt && maint_ready && !mem_req && !fetch_rvalid, "R6 after reset",
            {28'd0, fetch_gnt, maint_ready, mem_req, fetch_rvalid}, 32'hC);

        // R1/R2 basic miss then hits
        fetch(32'h100, "R2 miss data");
        fetch(32'h10C, "R1 hit data");
        fetch(32'h118, "R1 hit data");
        fetch(32'h2008, "R2 miss mid-line");
        fetch(32'h201C, "R2 miss last word");

        // R9 staleness, R5 line invalidate
        ovr[32'h104] = 32'hCAFE0104;
        fetch(32'h104, "R9 stale word");
        maint(1'b1, 32'h104);
        fetch(32'h104, "R5 refetched after line inv");
        fetch(32'h2000, "R5 other line kept");
        maint(1'b1, 32'h7000);
        fetch(32'h2004, "R5 non-resident inv no effect");

        // R4 nonzero whole-cache command ignored, zero clears
        maint(1'b0, 32'h1);
        fetch(32'h108, "R4 nonzero ignored");
        maint(1'b0, 32'h0);
        fetch(32'h108, "R4 cleared all");

        // R7 round-robin with a locked way
        for (int k = 0; k < 4; k++) fetch(s3(k), "R7 fill set");
        fetch(s3(0), "R7 resident");
        w0 = find_way(s3(0));
        lock_mask = 4'(1 << w0);
        for (int k = 4; k < 8; k++) fetch(s3(k), "R7 misses with lock");
        fetch(s3(0), "R7 locked line kept");
        fetch(s3(5), "R7 replacement order");
        fetch(s3(1), "R7 replacement order");

        // R8 all ways locked
        lock_mask = 4'hF;
        fetch(s3(9), "R8 locked miss data");
        fetch(s3(9), "R8 not cached");
        fetch(s3(0), "R8 locked hit");

        // R4 whole-cache clear removes locked line
        lock_mask = 4'(1 << w0);
        maint(1'b0, 32'h0);
        fetch(s3(0), "R4 locked line cleared");
        lock_mask = 4'h0;

        // R3 off mode
        fetch(32'h300, "R3 warm line");
        cache_on = 1'b0;
        fetch(32'h300, "R3 off resident");
        fetch(32'h4000, "R3 off single");
        fetch(32'h4000, "R3 off single again");
        cache_on = 1'b1;
        fetch(32'h4000, "R3 no fill while off");
        fetch(32'h304, "R3 contents kept");

        // R10 command during fill
        fork
            fetch(32'h5040, "R10 fill completes");
            begin
                repeat (5) @(negedge clk);
                maint_valid = 1'b1; maint_op = 1'b1; maint_data = 32'h5040;
                @(negedge clk); maint_valid = 1'b0;
                chk(!maint_ready, "R10 held during fill", {31'd0, maint_ready}, 32'd0);
            end
        join
        model_maint(1'b1, 32'h5040);
        fetch(32'h5044, "R10 applied after fill");

        // Mixed sweep against the model
        for (int i = 0; i < 80; i++) begin
            logic [31:0] a;
            a = {16'd0, 5'($urandom_range(0, 5)), 6'(($urandom_range(0, 2) == 0) ? 1 : ($urandom_range(0, 1) ? 2 : 9)),
                 3'($urandom_range(0, 7)), 2'b00};
            if ($urandom_range(0, 9) == 0) maint(1'b1, a);
            else fetch(a, "R7 sweep");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule